// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block places received frames into a circular region of local memory that is divided into 256-byte pages. Frames arrive as a byte stream with start and end markers. Each stored frame is preceded by a 4-byte header in the first bytes of its page. Payload bytes that reach the end of the ring continue at its first page. When a frame has been stored, the current-page pointer moves to the page where the next frame will begin.

Before a frame is accepted, the block checks that the ring has room for a maximum-size frame. The free space is measured between the current page and the host's boundary page. A frame that arrives while the receiver is halted, or while the ring lacks room, is consumed from the stream and discarded.

The host owns the ring limits, the boundary page and the run control. It may also load the current page directly. Filtering by destination address happens upstream of this block. Host reads of the ring are outside this block.

Top module: `rx_ring_writer`

## Requirements
- R1: A stored frame's header occupies byte offsets 0..3 of the page that was current when the frame started. Offset 0 holds the status byte, offset 1 the next-frame page, offset 2 the low byte of the total length and offset 3 its high byte. Payload byte k is stored at offset 4+k.
- R2: The total length is the stored byte count plus 4. A frame shorter than 60 bytes is padded with zero bytes up to 60 before the length is taken.
- R3: The next-frame page is the start page plus ceil((total length + 4) / 256) pages. If the result is at or beyond the stop page, the ring size (stop − start pages) is subtracted.
- R4: A payload or pad byte whose address would equal the stop address (stop page × 256) is written at the start address instead, and writing continues from there.
- R5: ring_full is high when the free space is below 1518 bytes. Free space is (bnd − cur) × 256 when cur < bnd, and otherwise ((stop − start) − (cur − bnd)) × 256. Equal cur and bnd therefore means a fully empty ring.
- R6: A frame whose start byte arrives while rx_run is low or ring_full is high is consumed but dropped. It causes no memory write, no rx_done and no change to cur_pg or rx_status.
- R7: The status byte is 0x01. It is 0x21 when bit 0 of the frame's first byte is set (multicast or broadcast destination).
- R8: The last header byte appears on the write port in the same cycle that cur_pg takes the next-frame page, rx_status takes the status byte and rx_done is high. rx_done is high for exactly one cycle.
- R9: The port issues at most one byte write per clock. A stored frame of n bytes produces exactly max(n,60)+4 writes. in_ready stays low from the cycle after the end byte until cur_pg has been updated.
- R10: A pulse on cur_load sets cur_pg to cur_load_pg on the next edge. When a frame completes on that same edge, the frame's update takes priority.
- R11: Reset sets cur_pg and rx_status to 0, rx_done and mem_we low, and in_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_run | input | 1 | Receiver running; low drops arriving frames |
| ring_start_pg | input | 8 | First page of the ring |
| ring_stop_pg | input | 8 | Page one past the last page of the ring |
| bnd_pg | input | 8 | Host boundary page (oldest page not yet released) |
| cur_load | input | 1 | Load cur_pg from cur_load_pg |
| cur_load_pg | input | 8 | Page value for a host load |
| in_valid | input | 1 | Stream byte valid |
| in_sop | input | 1 | Byte is the first of a frame |
| in_eop | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts a stream byte this cycle |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| cur_pg | output | 8 | Current page: where the next frame starts |
| rx_status | output | 8 | Status byte of the last stored frame |
| rx_done | output | 1 | One-cycle pulse when a frame is stored |
| ring_full | output | 1 | Ring lacks room for a maximum-size frame |

## Verification
The assertions assume that the start page is below the stop page, that cur_pg and bnd_pg lie inside the ring, and that the ring limits stay constant while a frame is in flight. They also assume frames are no longer than 1514 bytes. The bench changes limits, boundary and run control only between frames, with the stream idle. Its frames are at most 600 bytes long, and every page it loads lies between the start and stop pages. The single mid-frame host load it performs also targets a page inside the ring.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_DROP,
    ST_PAD,
    ST_HDR
  } wr_state_e;

  localparam int unsigned STAT_GOOD_BIT  = 0;
  localparam int unsigned STAT_GROUP_BIT = 5;

  function automatic logic [7:0] make_status(input logic grp);
    logic [7:0] s;
    s = '0;
    s[STAT_GOOD_BIT]  = 1'b1;
    s[STAT_GROUP_BIT] = grp;
    return s;
  endfunction

endpackage

// File: rtl/rx_ring_space.sv
// Room check: is there space for one maximum-size frame between cur and bnd.
module rx_ring_space #(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned LIMIT  = 1518
) (
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  input  logic [PAGE_W-1:0] bnd_pg,
  input  logic [PAGE_W-1:0] cur_pg,
  output logic              full
);
  localparam int unsigned PW = PAGE_W + 1;
  localparam int unsigned BW = PW + OFF_W;

  logic [PW-1:0] free_pg;
  logic [BW-1:0] free_bytes;

  always_comb begin
    if (cur_pg < bnd_pg) begin
      free_pg = PW'(bnd_pg) - PW'(cur_pg);
    end else begin
      free_pg = (PW'(stop_pg) - PW'(start_pg)) - (PW'(cur_pg) - PW'(bnd_pg));
    end
    free_bytes = {free_pg, {OFF_W{1'b0}}};
    full       = (free_bytes < BW'(LIMIT));
  end

endmodule

// File: rtl/rx_ring_link.sv
// Next-frame page: round length plus CRC room up to whole pages, wrap once.
module rx_ring_link #(
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned OFF_W     = 8,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned CRC_BYTES = 4
) (
  input  logic [PAGE_W-1:0] base_pg,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  input  logic [LEN_W-1:0]  total_len,
  output logic [PAGE_W-1:0] next_pg
);
  localparam int unsigned PAGE_SZ = 1 << OFF_W;
  localparam int unsigned SW      = LEN_W + 2;
  localparam int unsigned NW      = ((SW - OFF_W) > PAGE_W ? (SW - OFF_W) : PAGE_W) + 1;

  logic [SW-1:0]      span;
  logic [SW-OFF_W-1:0] n_pages;
  logic [NW-1:0]      raw_pg;
  logic [NW-1:0]      wrap_pg;
  logic               unused_bits;

  always_comb begin
    span    = SW'(total_len) + SW'(CRC_BYTES) + SW'(PAGE_SZ - 1);
    n_pages = span[SW-1:OFF_W];
    raw_pg  = NW'(base_pg) + NW'(n_pages);
    if (raw_pg >= NW'(stop_pg)) begin
      wrap_pg = raw_pg - (NW'(stop_pg) - NW'(start_pg));
    end else begin
      wrap_pg = raw_pg;
    end
    next_pg = wrap_pg[PAGE_W-1:0];
  end

  assign unused_bits = ^{span[OFF_W-1:0], wrap_pg[NW-1:PAGE_W]};

endmodule

// File: rtl/rx_ring_port.sv
// Registered byte write port plus the ring-wrapping successor address.
module rx_ring_port #(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFF_W  = 8,
  localparam int unsigned ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] succ_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  logic [ADDR_W-1:0] inc_addr;
  logic [ADDR_W-1:0] start_a;
  logic [ADDR_W-1:0] stop_a;

  always_comb begin
    start_a   = {start_pg, {OFF_W{1'b0}}};
    stop_a    = {stop_pg, {OFF_W{1'b0}}};
    inc_addr  = wr_addr + ADDR_W'(1);
    succ_addr = (inc_addr == stop_a) ? start_a : inc_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= wr_en;
      if (wr_en) begin
        mem_addr  <= wr_addr;
        mem_wdata <= wr_data;
      end
    end
  end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rx_ring_pkg::*;
#(
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned OFF_W     = 8,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned HDR_BYTES = 4,
  parameter int unsigned CRC_BYTES = 4,
  parameter int unsigned MIN_FRAME = 60,
  parameter int unsigned MAX_FRAME = 1514
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_run,
  input  logic [PAGE_W-1:0]          ring_start_pg,
  input  logic [PAGE_W-1:0]          ring_stop_pg,
  input  logic [PAGE_W-1:0]          bnd_pg,
  input  logic                       cur_load,
  input  logic [PAGE_W-1:0]          cur_load_pg,
  input  logic                       in_valid,
  input  logic                       in_sop,
  input  logic                       in_eop,
  input  logic [7:0]                 in_data,
  output logic                       in_ready,
  output logic                       mem_we,
  output logic [PAGE_W+OFF_W-1:0]    mem_addr,
  output logic [7:0]                 mem_wdata,
  output logic [PAGE_W-1:0]          cur_pg,
  output logic [7:0]                 rx_status,
  output logic                       rx_done,
  output logic                       ring_full
);
  localparam int unsigned ADDR_W = PAGE_W + OFF_W;
  localparam int unsigned HIDX_W = $clog2(HDR_BYTES);
  localparam int unsigned ROOM   = MAX_FRAME + HDR_BYTES;

  wr_state_e         st_q, st_n;
  logic [ADDR_W-1:0] wptr_q, wptr_n;
  logic [LEN_W-1:0]  cnt_q, cnt_n, cnt_inc;
  logic [PAGE_W-1:0] fpg_q, fpg_n;
  logic              grp_q, grp_n;
  logic [HIDX_W-1:0] hidx_q, hidx_n;
  logic [PAGE_W-1:0] cur_q, cur_n;
  logic [7:0]        stat_q, stat_n;
  logic              done_q, done_n;

  logic              accept;
  logic              fin;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] succ_addr;
  logic [7:0]        wr_data;
  logic [LEN_W-1:0]  total_len;
  logic [PAGE_W-1:0] next_pg;
  logic [7:0]        status_byte;

  // ---------------------------------------------------------------------
  // Helpers
  // ---------------------------------------------------------------------
  rx_ring_space #(
    .PAGE_W (PAGE_W),
    .OFF_W  (OFF_W),
    .LIMIT  (ROOM)
  ) u_space (
    .start_pg (ring_start_pg),
    .stop_pg  (ring_stop_pg),
    .bnd_pg   (bnd_pg),
    .cur_pg   (cur_q),
    .full     (ring_full)
  );

  assign total_len = cnt_q + LEN_W'(HDR_BYTES);

  rx_ring_link #(
    .PAGE_W    (PAGE_W),
    .OFF_W     (OFF_W),
    .LEN_W     (LEN_W),
    .CRC_BYTES (CRC_BYTES)
  ) u_link (
    .base_pg   (fpg_q),
    .start_pg  (ring_start_pg),
    .stop_pg   (ring_stop_pg),
    .total_len (total_len),
    .next_pg   (next_pg)
  );

  rx_ring_port #(
    .PAGE_W (PAGE_W),
    .OFF_W  (OFF_W)
  ) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_pg  (ring_start_pg),
    .stop_pg   (ring_stop_pg),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .succ_addr (succ_addr),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  // ---------------------------------------------------------------------
  // Write address select (kept apart from the next-state logic)
  // ---------------------------------------------------------------------
  always_comb begin
    unique case (st_q)
      ST_IDLE: wr_addr = {cur_q, {OFF_W{1'b0}}} + ADDR_W'(HDR_BYTES);
      ST_HDR:  wr_addr = {fpg_q, {OFF_W{1'b0}}} + ADDR_W'(hidx_q);
      default: wr_addr = wptr_q;
    endcase
  end

  assign in_ready    = (st_q == ST_IDLE) || (st_q == ST_DATA) || (st_q == ST_DROP);
  assign accept      = in_valid && in_ready;
  assign cnt_inc     = cnt_q + LEN_W'(1);
  assign status_byte = make_status(grp_q);

  // ---------------------------------------------------------------------
  // Next-state logic
  // ---------------------------------------------------------------------
  always_comb begin
    st_n    = st_q;
    wptr_n  = wptr_q;
    cnt_n   = cnt_q;
    fpg_n   = fpg_q;
    grp_n   = grp_q;
    hidx_n  = hidx_q;
    wr_en   = 1'b0;
    wr_data = 8'h00;
    fin     = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (accept && in_sop) begin
          if (!rx_run || ring_full) begin
            if (!in_eop) st_n = ST_DROP;
          end else begin
            fpg_n   = cur_q;
            grp_n   = in_data[0];
            wr_en   = 1'b1;
            wr_data = in_data;
            cnt_n   = LEN_W'(1);
            wptr_n  = succ_addr;
            hidx_n  = '0;
            if (in_eop) begin
              st_n = (LEN_W'(1) < LEN_W'(MIN_FRAME)) ? ST_PAD : ST_HDR;
            end else begin
              st_n = ST_DATA;
            end
          end
        end
      end
      ST_DATA: begin
        if (accept) begin
          wr_en   = 1'b1;
          wr_data = in_data;
          cnt_n   = cnt_inc;
          wptr_n  = succ_addr;
          if (in_eop) begin
            st_n = (cnt_inc < LEN_W'(MIN_FRAME)) ? ST_PAD : ST_HDR;
          end
        end
      end
      ST_DROP: begin
        if (accept && in_eop) st_n = ST_IDLE;
      end
      ST_PAD: begin
        wr_en   = 1'b1;
        wr_data = 8'h00;
        cnt_n   = cnt_inc;
        wptr_n  = succ_addr;
        if (cnt_inc >= LEN_W'(MIN_FRAME)) st_n = ST_HDR;
      end
      ST_HDR: begin
        wr_en = 1'b1;
        unique case (hidx_q)
          HIDX_W'(0): wr_data = status_byte;
          HIDX_W'(1): wr_data = 8'(next_pg);
          HIDX_W'(2): wr_data = total_len[7:0];
          default:    wr_data = 8'(total_len >> 8);
        endcase
        hidx_n = hidx_q + HIDX_W'(1);
        if (hidx_q == HIDX_W'(HDR_BYTES - 1)) begin
          fin  = 1'b1;
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase

    // frame completion has priority over a host load
    if (fin) begin
      cur_n = next_pg;
    end else if (cur_load) begin
      cur_n = cur_load_pg;
    end else begin
      cur_n = cur_q;
    end
    stat_n = fin ? status_byte : stat_q;
    done_n = fin;
  end

  // ---------------------------------------------------------------------
  // Registers
  // ---------------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wptr_q <= '0;
      cnt_q  <= '0;
      fpg_q  <= '0;
      grp_q  <= 1'b0;
      hidx_q <= '0;
      cur_q  <= '0;
      stat_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      wptr_q <= wptr_n;
      cnt_q  <= cnt_n;
      fpg_q  <= fpg_n;
      grp_q  <= grp_n;
      hidx_q <= hidx_n;
      cur_q  <= cur_n;
      stat_q <= stat_n;
      done_q <= done_n;
    end
  end

  assign cur_pg    = cur_q;
  assign rx_status = stat_q;
  assign rx_done   = done_q;

  // ---------------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------------
  p_addr_in_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= {ring_start_pg, {OFF_W{1'b0}}}) &&
               (mem_addr <  {ring_stop_pg,  {OFF_W{1'b0}}}));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  p_done_with_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> mem_we);

  p_status_form_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (rx_status[0] && ((rx_status & 8'hDE) == 8'h00)));

  p_cur_in_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (cur_pg >= ring_start_pg) && (cur_pg < ring_stop_pg));

  p_drop_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DROP) |=> !mem_we);

  p_ready_low_after_eop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && in_valid && in_eop) |=> !in_ready);

endmodule

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;

  logic       clk;
  logic       rst_n;
  logic       rx_run;
  logic [7:0] ring_start_pg, ring_stop_pg, bnd_pg;
  logic       cur_load;
  logic [7:0] cur_load_pg;
  logic       in_valid, in_sop, in_eop;
  logic [7:0] in_data;
  logic       in_ready, mem_we, rx_done, ring_full;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, cur_pg, rx_status;

  int n_chk = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  int done_cnt = 0;
  bit finished = 0;

  logic [7:0] bmem [0:65535];
  logic [7:0] fbuf [0:1599];

  rx_ring_writer u_rx_ring_writer (
    .clk (clk), .rst_n (rst_n), .rx_run (rx_run),
    .ring_start_pg (ring_start_pg), .ring_stop_pg (ring_stop_pg), .bnd_pg (bnd_pg),
    .cur_load (cur_load), .cur_load_pg (cur_load_pg),
    .in_valid (in_valid), .in_sop (in_sop), .in_eop (in_eop), .in_data (in_data),
    .in_ready (in_ready), .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
    .cur_pg (cur_pg), .rx_status (rx_status), .rx_done (rx_done), .ring_full (ring_full)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // write-port and done monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        bmem[mem_addr] = mem_wdata;
        wr_cnt++;
      end
      if (rx_done) done_cnt++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_next(input int base_pg, input int len);
    int t, span, nx;
    t    = (len < 60 ? 60 : len) + 4;
    span = ((t + 4 + 255) / 256) * 256;
    nx   = base_pg * 256 + span;
    if (nx >= ring_stop_pg * 256) nx -= (ring_stop_pg - ring_start_pg) * 256;
    return nx / 256;
  endfunction

  function automatic int ring_addr(input int a);
    if (a >= ring_stop_pg * 256) return a - (ring_stop_pg - ring_start_pg) * 256;
    return a;
  endfunction

  task automatic drive_frame(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = (i == len - 1);
      in_data  = fbuf[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic fill(input int len, input logic [7:0] b0, input int seed);
    for (int i = 0; i < len; i++) fbuf[i] = 8'((seed + i * 7) & 255);
    fbuf[0] = b0;
  endtask

  task automatic set_cur(input logic [7:0] pg);
    @(negedge clk);
    cur_load = 1'b1; cur_load_pg = pg;
    @(negedge clk);
    cur_load = 1'b0;
    chk("R10", "host load of cur_pg", cur_pg, pg);
  endtask

  // stores one frame and checks header, payload, padding, pointer and status
  task automatic run_frame(input string tag, input int len, input logic [7:0] b0,
                           input int seed, input bit load_mid);
    int base, wr0, nx, stat, pad_len, total, bad_data, bad_pad, wait_c;
    base = cur_pg;
    fill(len, b0, seed);
    nx      = exp_next(base, len);
    stat    = b0[0] ? 8'h21 : 8'h01;
    pad_len = len < 60 ? 60 : len;
    total   = pad_len + 4;
    wr0     = wr_cnt;
    drive_frame(len);
    chk("R9", {tag, " in_ready low after end byte"}, in_ready, 0);
    if (load_mid) begin cur_load = 1'b1; cur_load_pg = 8'h55; end
    wait_c = 0;
    while (!rx_done && wait_c < 4000) begin @(negedge clk); wait_c++; end
    cur_load = 1'b0;
    chk("R8", {tag, " rx_done seen"}, rx_done, 1);
    chk(load_mid ? "R10" : "R8", {tag, " cur_pg after frame"}, cur_pg, nx);
    chk("R7", {tag, " rx_status"}, rx_status, stat);
    @(negedge clk);
    chk("R8", {tag, " rx_done one cycle"}, rx_done, 0);
    chk("R9", {tag, " in_ready back"}, in_ready, 1);
    chk("R9", {tag, " write count"}, wr_cnt - wr0, pad_len + 4);
    chk("R7", {tag, " header status"}, bmem[base * 256 + 0], stat);
    chk("R3", {tag, " header next page"}, bmem[base * 256 + 1], nx);
    chk("R2", {tag, " header length low"}, bmem[base * 256 + 2], total & 255);
    chk("R1", {tag, " header length high"}, bmem[base * 256 + 3], total >> 8);
    bad_data = 0;
    bad_pad = 0;
    for (int k = 0; k < pad_len; k++) begin
      if (k < len) begin
        if (bmem[ring_addr(base * 256 + 4 + k)] != fbuf[k]) bad_data++;
      end else if (bmem[ring_addr(base * 256 + 4 + k)] != 8'h00) begin
        bad_pad++;
      end
    end
    chk("R1", {tag, " payload bytes wrong (R4 wrap)"}, bad_data, 0);
    chk("R2", {tag, " pad bytes nonzero"}, bad_pad, 0);
  endtask

  task automatic drop_frame(input string req, input int len);
    int wr0, dn0, cur0, st0;
    wr0 = wr_cnt; dn0 = done_cnt; cur0 = cur_pg; st0 = rx_status;
    fill(len, 8'h02, 3);
    drive_frame(len);
    repeat (80) @(negedge clk);
    chk(req, "dropped frame writes", wr_cnt - wr0, 0);
    chk(req, "dropped frame rx_done", done_cnt - dn0, 0);
    chk(req, "dropped frame cur_pg", cur_pg, cur0);
    chk(req, "dropped frame rx_status", rx_status, st0);
  endtask

  task automatic t_reset;
    chk("R11", "in_ready", in_ready, 1);
    chk("R11", "cur_pg", cur_pg, 0);
    chk("R11", "rx_status", rx_status, 0);
    chk("R11", "rx_done", rx_done, 0);
    chk("R11", "mem_we", mem_we, 0);
  endtask

  task automatic t_basic;
    ring_start_pg = 8'h40; ring_stop_pg = 8'h60; bnd_pg = 8'h40;
    set_cur(8'h40);
    chk("R5", "equal cur and bnd is empty", ring_full, 0);
    run_frame("short unicast", 10, 8'h02, 5, 1'b0);
    run_frame("multicast", 100, 8'h01, 9, 1'b0);
    run_frame("one-page edge", 248, 8'h04, 11, 1'b0);
    run_frame("two-page edge", 252, 8'h06, 13, 1'b0);
  endtask

  task automatic t_wrap;
    bnd_pg = 8'h50;
    set_cur(8'h5F);
    run_frame("ring wrap R4", 600, 8'h08, 17, 1'b0);
    chk("R3", "wrapped next page", cur_pg, 8'h42);
  endtask

  task automatic t_priority;
    bnd_pg = 8'h40;
    run_frame("load during frame", 20, 8'h0A, 21, 1'b1);
  endtask

  task automatic t_full;
    @(negedge clk); bnd_pg = 8'h49;
    @(negedge clk); chk("R5", "1536 bytes free", ring_full, 0);
    bnd_pg = 8'h48;
    @(negedge clk); chk("R5", "1280 bytes free", ring_full, 1);
    drop_frame("R6", 50);
    set_cur(8'h5B); bnd_pg = 8'h40;
    @(negedge clk); chk("R5", "cur above bnd, 1280 free", ring_full, 1);
    set_cur(8'h43);
  endtask

  task automatic t_stopped;
    @(negedge clk); rx_run = 1'b0;
    chk("R5", "room while stopped", ring_full, 0);
    drop_frame("R6", 30);
    rx_run = 1'b1;
    run_frame("exact minimum", 60, 8'h0C, 25, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; rx_run = 1'b1;
    ring_start_pg = 8'h40; ring_stop_pg = 8'h60; bnd_pg = 8'h40;
    cur_load = 1'b0; cur_load_pg = 8'h00;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = 8'h00;
    for (int a = 0; a < 65536; a++) bmem[a] = 8'hEE;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_priority();
    t_full();
    t_stopped();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule